// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table held in memory. A caller hands it a virtual address and an access type while it is idle. It then reads the directory entry for that address and, if that entry is present, the leaf entry it points to. It reports either the translated address with the leaf's permission bits, or a fault. The fault says whether an entry was absent or whether the leaf forbids the access.

The physical page number of the current directory comes in on a dedicated input and is sampled when a request is accepted. All table traffic goes over one word-wide memory port. A request on that port is held until the port is ready. Read data returns later, qualified by a response-valid strobe. A store to a leaf whose dirty flag is clear causes one extra memory write, which puts the leaf back with the dirty flag set before the walk completes. Only one walk runs at a time.

Top module: `ptw_walker`

## Requirements
- R1: While and after reset, with no request pending, `req_ready` is 1 and `done`, `fault` and `mem_req_valid` are 0.
- R2: The first memory read of a walk is at address {dir_base_ppn, 12'h000} + 4 × vaddr[31:22].
- R3: When the directory entry is present, the second read is at address {entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R4: An entry holds its page number in bits [31:12]. It holds present in bit 0, read-allowed in bit 1, write-allowed in bit 2, execute-allowed in bit 3 and dirty in bit 4.
- R5: A successful walk pulses `done` for one cycle. At that point `out_pa` = {leaf[31:12], vaddr[11:0]} and `out_perm` = {X, W, R} taken from the leaf.
- R6: An entry whose present bit is 0, at either level, ends the walk. `fault` pulses with `fault_perm` = 0 and `out_pa` = 0. There are no further reads and no write.
- R7: The access codes are 0 = load (needs R), 1 = store (needs W) and 2 = fetch (needs X); code 3 is never allowed. When the leaf does not allow the access, `fault` pulses with `fault_perm` = 1 and `out_pa` = 0, and nothing is written.
- R8: A permitted store to a leaf with dirty = 0 writes (leaf | 32'h10) to the leaf's own address before `done`. Any other successful walk writes nothing.
- R9: From the cycle after a request is accepted until the cycle that `done` or `fault` pulses, `req_ready` is 0. Requests presented during that time are ignored.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the memory request stays asserted with unchanged address and write flag.
- R11: `done` and `fault` are never 1 in the same cycle, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| dir_base_ppn | input | 20 | Page number of the current directory |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Translation complete pulse |
| fault | output | 1 | Walk failed pulse |
| fault_perm | output | 1 | Fault cause: 0 not present, 1 permission |
| out_pa | output | 32 | Translated physical address |
| out_perm | output | 3 | Leaf permissions {X, W, R} |

## Verification
The hardest case to reach from the ports is a request that arrives while a walk is in flight and the memory is also stalling, because it must be ignored. The bench raises a second request with a different address right after the first is accepted. It checks that the result, the read count and the write-back all belong to the first request. A separate run holds `mem_req_ready` low for two cycles out of three during a store walk that needs a dirty write-back, so that every memory request, including the write, has to wait.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DIR_RQ,
    S_DIR_RS,
    S_LEAF_RQ,
    S_LEAF_RS,
    S_MARK_RQ
  } walk_e;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_D = 4;
  localparam int FLAG_W = 5;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [PA_W-OFF_W-1:0] base_ppn,
  input  logic [IDX_W-1:0]      idx,
  output logic [PA_W-1:0]       addr
);
  localparam int ENT_SHIFT = 2;

  always_comb begin
    addr = {base_ppn, {OFF_W{1'b0}}} + (PA_W'(idx) << ENT_SHIFT);
  end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [1:0]        acc,
  output logic              allowed,
  output logic              mark_dirty
);
  logic type_ok;

  always_comb begin
    case (acc)
      ACC_LOAD:  type_ok = flags[BIT_R];
      ACC_STORE: type_ok = flags[BIT_W];
      ACC_FETCH: type_ok = flags[BIT_X];
      default:   type_ok = 1'b0;
    endcase
    allowed    = flags[BIT_V] && type_ok;
    mark_dirty = allowed && (acc == ACC_STORE) && !flags[BIT_D];
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_acc,
  input  logic [PA_W-OFF_W-1:0] dir_base_ppn,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_we,
  output logic [PA_W-1:0]       mem_addr,
  output logic [PA_W-1:0]       mem_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [PA_W-1:0]       mem_rdata,
  output logic                  done,
  output logic                  fault,
  output logic                  fault_perm,
  output logic [PA_W-1:0]       out_pa,
  output logic [2:0]            out_perm
);
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int DIR_HI = VA_W - 1;
  localparam int DIR_LO = VA_W - IDX_W;
  localparam int TBL_HI = DIR_LO - 1;
  localparam int TBL_LO = DIR_LO - IDX_W;

  walk_e           st;
  logic [VA_W-1:0] va_q;
  logic [1:0]      acc_q;
  logic [PA_W-1:0] dir_addr, leaf_addr;
  logic            allowed, mark_dirty;

  ptw_addr_gen #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_addr (
    .base_ppn (dir_base_ppn),
    .idx      (req_vaddr[DIR_HI:DIR_LO]),
    .addr     (dir_addr)
  );

  ptw_addr_gen #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_leaf_addr (
    .base_ppn (mem_rdata[PA_W-1:OFF_W]),
    .idx      (va_q[TBL_HI:TBL_LO]),
    .addr     (leaf_addr)
  );

  ptw_perm_check u_perm (
    .flags      (mem_rdata[FLAG_W-1:0]),
    .acc        (acc_q),
    .allowed    (allowed),
    .mark_dirty (mark_dirty)
  );

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_DIR_RQ) || (st == S_LEAF_RQ) || (st == S_MARK_RQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      va_q       <= '0;
      acc_q      <= '0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_we     <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_perm <= 1'b0;
      out_pa     <= '0;
      out_perm   <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            acc_q    <= req_acc;
            mem_addr <= dir_addr;
            mem_we   <= 1'b0;
            st       <= S_DIR_RQ;
          end
        end
        S_DIR_RQ:  if (mem_req_ready) st <= S_DIR_RS;
        S_DIR_RS: begin
          if (mem_rsp_valid) begin
            if (!mem_rdata[BIT_V]) begin
              fault      <= 1'b1;
              fault_perm <= 1'b0;
              out_pa     <= '0;
              st         <= S_IDLE;
            end else begin
              mem_addr <= leaf_addr;
              st       <= S_LEAF_RQ;
            end
          end
        end
        S_LEAF_RQ: if (mem_req_ready) st <= S_LEAF_RS;
        S_LEAF_RS: begin
          if (mem_rsp_valid) begin
            if (!allowed) begin
              fault      <= 1'b1;
              fault_perm <= mem_rdata[BIT_V];
              out_pa     <= '0;
              st         <= S_IDLE;
            end else begin
              out_pa   <= {mem_rdata[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
              out_perm <= {mem_rdata[BIT_X], mem_rdata[BIT_W], mem_rdata[BIT_R]};
              if (mark_dirty) begin
                mem_we    <= 1'b1;
                mem_wdata <= mem_rdata | (PA_W'(1) << BIT_D);
                st        <= S_MARK_RQ;
              end else begin
                done <= 1'b1;
                st   <= S_IDLE;
              end
            end
          end
        end
        S_MARK_RQ: begin
          if (mem_req_ready) begin
            mem_we <= 1'b0;
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic unused_ppn;
  assign unused_ppn = ^{PPN_W{1'b0}};
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_we,
  input logic [PA_W-1:0] mem_addr,
  input logic [PA_W-1:0] mem_wdata,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] out_pa
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);

  p_fault_no_xlate_r6: assert property (@(posedge clk) disable iff (rst)
    fault |-> (out_pa == '0));

  p_mark_sets_dirty_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_we) |-> mem_wdata[4]);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we)));

  p_excl_end_r11: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_fault_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .done          (done),
  .fault         (fault),
  .out_pa        (out_pa)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [19:0] dir_base_ppn = 20'h10005;
  logic        mem_req_valid, mem_req_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, fault, fault_perm;
  logic [31:0] out_pa;
  logic [2:0]  out_perm;

  always #4 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .dir_base_ppn(dir_base_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_perm(fault_perm),
    .out_pa(out_pa), .out_perm(out_perm)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: reads answer two cycles after acceptance
  logic [31:0] mem_q [logic [31:0]];
  bit          stall_en = 1'b0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_wr_addr = '0, last_wr_data = '0;
  logic [31:0] rsp_data = '0;
  int          rsp_cnt = 0;
  int          both_seen = 0;

  assign mem_req_ready = !stall_en || (cyc % 3 == 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (done && fault) both_seen++;
    if (rsp_cnt != 0) begin
      rsp_cnt <= rsp_cnt - 1;
      if (rsp_cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rdata     <= rsp_data;
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        mem_q[mem_addr] = mem_wdata;
        wr_cnt++;
        last_wr_addr = mem_addr;
        last_wr_data = mem_wdata;
      end else begin
        rd_cnt++;
        rsp_data <= mem_q.exists(mem_addr) ? mem_q[mem_addr] : 32'h0;
        rsp_cnt  <= 2;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [31:0] pde;
    logic [31:0] pte;
    logic        flt;
    logic        kind;
    logic [31:0] pa;
    logic        wb;
  } vec_t;

  // R4 field layout: ppn[31:12], V0 R1 W2 X3 D4; R7 codes: 0 load, 1 store, 2 fetch
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h7192a44c, 2'd1, 32'h12345001, 32'h14817007, 1'b0, 1'b0, 32'h1481744c, 1'b1},
    '{32'h7192a44c, 2'd0, 32'h12345001, 32'h14817017, 1'b0, 1'b0, 32'h1481744c, 1'b0},
    '{32'h00400010, 2'd0, 32'h00002000, 32'h00005003, 1'b1, 1'b0, 32'h0,        1'b0},
    '{32'h00400010, 2'd0, 32'h00002001, 32'h00005000, 1'b1, 1'b0, 32'h0,        1'b0},
    '{32'h00400010, 2'd2, 32'h00002001, 32'h00005003, 1'b1, 1'b1, 32'h0,        1'b0},
    '{32'h00400010, 2'd1, 32'h00002001, 32'h00005003, 1'b1, 1'b1, 32'h0,        1'b0},
    '{32'h00400010, 2'd2, 32'h00002001, 32'h00005009, 1'b0, 1'b0, 32'h00005010, 1'b0},
    '{32'hffffffff, 2'd0, 32'habcde001, 32'h99999003, 1'b0, 1'b0, 32'h99999fff, 1'b0},
    '{32'h00000000, 2'd1, 32'h00003001, 32'h00007017, 1'b0, 1'b0, 32'h00007000, 1'b0},
    '{32'h00000abc, 2'd1, 32'h00003001, 32'h0000700f, 1'b0, 1'b0, 32'h00007abc, 1'b1},
    '{32'h00400010, 2'd3, 32'h00002001, 32'h0000500f, 1'b1, 1'b1, 32'h0,        1'b0}
  };

  function automatic logic [31:0] dir_ent_addr(input logic [31:0] va);
    return {dir_base_ppn, 12'h000} + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] leaf_ent_addr(input logic [31:0] pde, input logic [31:0] va);
    return {pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
  endfunction

  task automatic install(input vec_t v);
    mem_q.delete();
    mem_q[dir_ent_addr(v.va)] = v.pde;
    if (v.pde[0]) mem_q[leaf_ent_addr(v.pde, v.va)] = v.pte;
    rd_cnt = 0;
    wr_cnt = 0;
  endtask

  logic got_fault, got_done;

  task automatic start(input logic [31:0] va, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_acc   = acc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_walk();
    got_fault = 1'b0;
    got_done  = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done || fault) begin
        got_done  = done;
        got_fault = fault;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_vec(input vec_t v, input int n);
    chk(got_done || got_fault, $sformatf("R5/R6 vec%0d walk ended", n), 32'(got_done), 32'h1);
    chk(got_fault == v.flt, $sformatf("R6/R7 vec%0d fault flag", n), 32'(got_fault), 32'(v.flt));
    if (v.flt) begin
      chk(fault_perm == v.kind, $sformatf("R6/R7 vec%0d fault cause", n), 32'(fault_perm), 32'(v.kind));
      chk(out_pa == 32'h0, $sformatf("R6 vec%0d no translation", n), out_pa, 32'h0);
      chk(rd_cnt == (v.pde[0] ? 2 : 1), $sformatf("R6 vec%0d read count", n), rd_cnt, v.pde[0] ? 2 : 1);
    end else begin
      chk(out_pa == v.pa, $sformatf("R5 R2 R3 vec%0d physical address", n), out_pa, v.pa);
      chk(out_perm == v.pte[3:1], $sformatf("R5 R4 vec%0d permissions", n), 32'(out_perm), 32'(v.pte[3:1]));
    end
    chk(wr_cnt == (v.wb ? 1 : 0), $sformatf("R8 vec%0d write count", n), wr_cnt, v.wb ? 1 : 0);
    if (v.wb) begin
      chk(last_wr_addr == leaf_ent_addr(v.pde, v.va), $sformatf("R8 vec%0d write address", n),
          last_wr_addr, leaf_ent_addr(v.pde, v.va));
      chk(last_wr_data == (v.pte | 32'h10), $sformatf("R8 vec%0d write data", n),
          last_wr_data, v.pte | 32'h10);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(req_ready == 1'b1 && done == 1'b0 && fault == 1'b0 && mem_req_valid == 1'b0,
        "R1 reset outputs", {28'h0, req_ready, done, fault, mem_req_valid}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req_valid == 1'b0, "R1 idle after reset",
        {30'h0, req_ready, mem_req_valid}, 32'h2);

    for (int n = 0; n < NV; n++) begin
      install(VECS[n]);
      start(VECS[n].va, VECS[n].acc);
      finish_walk();
      check_vec(VECS[n], n);
      @(negedge clk);
    end

    // R9: second request during a walk is ignored
    install(VECS[0]);
    start(VECS[0].va, VECS[0].acc);
    chk(req_ready == 1'b0, "R9 busy after accept", 32'(req_ready), 32'h0);
    req_valid = 1'b1;
    req_vaddr = 32'h00400010;
    req_acc   = 2'd0;
    stall_en  = 1'b1;
    finish_walk();
    req_valid = 1'b0;
    stall_en  = 1'b0;
    check_vec(VECS[0], 100);
    chk(rd_cnt == 2, "R9 no extra walk reads", rd_cnt, 2);
    repeat (10) @(negedge clk);
    chk(rd_cnt == 2, "R9 ignored request not started later", rd_cnt, 2);

    // R10: stalled memory port on a write-back walk
    install(VECS[9]);
    stall_en = 1'b1;
    start(VECS[9].va, VECS[9].acc);
    finish_walk();
    stall_en = 1'b0;
    check_vec(VECS[9], 101);

    // R11: done and fault never together
    chk(both_seen == 0, "R11 done and fault exclusive", both_seen, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule